// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block keeps a small byte queue filled with code ahead of the instruction decoder. It fetches whole aligned 16-byte lines over a shared memory bus and passes the bytes to the decoder one at a time, in address order, through a valid/ready pair. Alongside each byte it presents that byte's address. The block is the lowest-priority master on the bus. It raises a request only when no data transfer is waiting, so it runs only in bus cycles that would otherwise be idle.

Any break in sequential flow arrives on one redirect input. Jumps, task switches, exceptions and interrupts all use it. A redirect empties the queue, abandons any line still in flight and restarts fetching at the new address. Fetching stalls without faulting in two cases: when the next line would run past the code segment limit, and when the page-present flag is low. After reset the block fetches nothing until the first redirect gives it a start address.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset, `dec_valid` and `bus_req` stay low until the first `redirect_valid` pulse.
- R2: `bus_req` is low in every cycle in which `data_pending` is high. While the pending flag is held, no line is granted.
- R3: A redirect empties the queue, so `dec_valid` is low in the cycle after the pulse. The first byte delivered afterwards carries the redirect address.
- R4: After a redirect, the first line requested has address `redirect_addr` with its low 4 bits cleared. Bytes below the target address are never delivered.
- R5: Delivered bytes have strictly consecutive addresses (`dec_addr` rises by one per transfer). Each byte equals the bus data for that address: beat k of a line carries addresses base+4k to base+4k+3, with the lowest address in bits 7:0.
- R6: A line is requested only when its last byte (base+15) is at or below `seg_limit`. Fetching halts at the first line that would cross the limit.
- R7: While `page_present` is low no line is requested. Fetching resumes unchanged once it returns high.
- R8: The remaining beats of a line in flight when a redirect arrives are dropped, including a beat in the redirect cycle itself. No new request is made until all four beats of that line have arrived.
- R9: The queue holds 32 bytes. A new line is requested only when at least 16 bytes are free.
- R10: One byte leaves per clock in which `dec_valid` and `dec_ready` are both high, and none in any other clock.
- R11: A request is accepted at a clock edge where `bus_req` and `bus_gnt` are both high. `bus_req` then stays low until the fourth beat (`bus_rvalid`) of that line has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_valid | input | 1 | Non-sequential flow: flush and restart |
| redirect_addr | input | 32 | Byte address to restart at |
| seg_limit | input | 32 | Highest byte address inside the code segment |
| page_present | input | 1 | Page holding the next line (`bus_addr`) is present |
| data_pending | input | 1 | A data read or write is waiting for the bus |
| bus_req | output | 1 | Line fetch request |
| bus_addr | output | 32 | Aligned address of the next line |
| bus_gnt | input | 1 | Grant; request taken when high with `bus_req` |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | 32 | Read beat data, little-endian byte lanes |
| dec_valid | output | 1 | A code byte is available |
| dec_ready | input | 1 | Decoder takes the byte |
| dec_byte | output | 8 | Code byte at the head of the queue |
| dec_addr | output | 32 | Address of `dec_byte` |

## Verification
The bench redirects to an address that is not aligned, to check two things. A design that skipped the alignment would fetch the wrong line, and one that did not discard the leading bytes would hand the decoder bytes from before the target. It then redirects while a line is still arriving. If the stale beats were kept, data from the old address would appear under the new address. If the block issued a request before the last stale beat arrived, the bus model would detect the overlap. It also sets a segment limit that ends partway through a line, which exposes a design that checks only the line base instead of the line's last byte. Finally, it drains a full queue one byte at a time and expects the next request on exactly the sixteenth pop, so a free-space test that is off by one shows up.

// File: rtl/pfq_pkg.sv
// Shared definitions for the prefetch queue controller.
// Assumes byte-addressed code space and little-endian bus lanes.
package pfq_pkg;
    typedef logic [7:0] code_byte_t;
    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pfq_byte_queue.sv
// Circular byte queue: takes up to PUSH_MAX bytes per clock packed at the
// low lanes, gives one byte per clock at the head.
// Assumes DEPTH is a power of two and the caller never overfills it.
module pfq_byte_queue
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH    = 32,
    parameter int unsigned PUSH_MAX = 4,
    localparam int unsigned PTR_W   = $clog2(DEPTH),
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
    localparam int unsigned PN_W    = $clog2(PUSH_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [PN_W-1:0]            push_n,
    input  logic [PUSH_MAX*BYTE_W-1:0] push_data,
    input  logic                       pop,
    output code_byte_t                 head,
    output logic [CNT_W-1:0]           count
);
    code_byte_t         mem [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;

    // Store the packed bytes at consecutive slots after the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_MAX; i++) begin
            if (PN_W'(i) < push_n)
                mem[wr_ptr + PTR_W'(i)] <= push_data[i*BYTE_W +: BYTE_W];
        end
    end

    // Move the pointers and the fill level; a flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop);
            count  <= count + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    assign head = mem[rd_ptr];

    // R9
    q_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R10
    q_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/pfq_beat_pack.sv
// Drops the bytes of a bus beat that lie below the fetch target and packs
// the rest to the low lanes for the queue.
// Assumes kept bytes are always the upper lanes of a beat.
module pfq_beat_pack
    import pfq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned BEAT_BYTES = 4,
    localparam int unsigned BEAT_W    = BEAT_BYTES * BYTE_W,
    localparam int unsigned PN_W      = $clog2(BEAT_BYTES + 1)
) (
    input  logic              take,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [ADDR_W-1:0] keep_from,
    input  logic [BEAT_W-1:0] beat_data,
    output logic [PN_W-1:0]   push_n,
    output logic [BEAT_W-1:0] push_data
);
    logic [BEAT_BYTES-1:0] keep;

    // Mark each lane whose address is at or above the fetch target.
    always_comb begin
        for (int j = 0; j < BEAT_BYTES; j++)
            keep[j] = take && ((beat_addr + ADDR_W'(j)) >= keep_from);
    end

    // Count the kept lanes.
    always_comb begin
        push_n = '0;
        for (int j = 0; j < BEAT_BYTES; j++)
            push_n = push_n + PN_W'(keep[j]);
    end

    // Shift the kept upper lanes down by the number of dropped lanes.
    always_comb begin
        push_data = '0;
        for (int i = 0; i < BEAT_BYTES; i++) begin
            for (int j = 0; j < BEAT_BYTES; j++) begin
                if (PN_W'(j) == PN_W'(i) + PN_W'(BEAT_BYTES) - push_n)
                    push_data[i*BYTE_W +: BYTE_W] = beat_data[j*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/pfq_fetch_ctrl.sv
// Line fetch engine: decides when a line may be requested (bus idle,
// queue room, page present, whole line inside the segment), tracks the
// beats of the one line in flight and cancels it on a redirect.
// Assumes one outstanding line and beats returned in address order.
module pfq_fetch_ctrl #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 16,
    parameter int unsigned BEAT_BYTES = 4,
    parameter int unsigned CNT_W      = 6,
    localparam int unsigned NBEATS    = LINE_BYTES / BEAT_BYTES,
    localparam int unsigned BIDX_W    = (NBEATS > 1) ? $clog2(NBEATS) : 1,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned BOFF_W    = $clog2(BEAT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_valid,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              data_pending,
    input  logic              page_present,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [CNT_W-1:0]  free_bytes,
    input  logic              bus_gnt,
    input  logic              bus_rvalid,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              beat_take,
    output logic [ADDR_W-1:0] beat_addr
);
    logic              started;
    logic              busy;
    logic              cancel;
    logic [BIDX_W-1:0] beat_idx;
    logic [ADDR_W-1:0] line_addr;
    logic [ADDR_W-1:0] next_line;
    logic [ADDR_W:0]   line_end;
    logic              limit_ok;
    logic              space_ok;
    logic              grant;
    logic              beat_in;
    logic              last_beat;

    // Qualify a request: last byte of the line inside the segment, room
    // for a whole line, page present, and no data transfer waiting.
    always_comb begin
        line_end  = {1'b0, next_line} + (ADDR_W+1)'(LINE_BYTES - 1);
        limit_ok  = line_end <= {1'b0, seg_limit};
        space_ok  = free_bytes >= CNT_W'(LINE_BYTES);
        bus_req   = started && !busy && !redirect_valid && !data_pending
                    && page_present && limit_ok && space_ok;
        grant     = bus_req && bus_gnt;
        beat_in   = busy && bus_rvalid;
        last_beat = beat_idx == BIDX_W'(NBEATS - 1);
        beat_take = beat_in && !cancel && !redirect_valid;
        beat_addr = line_addr + ADDR_W'({beat_idx, {BOFF_W{1'b0}}});
    end

    assign bus_addr = next_line;

    // Advance the next-line pointer, or restart it at an aligned redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started   <= 1'b0;
            next_line <= '0;
        end else if (redirect_valid) begin
            started   <= 1'b1;
            next_line <= {redirect_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end else if (grant) begin
            next_line <= next_line + ADDR_W'(LINE_BYTES);
        end
    end

    // Track the line in flight, count its beats, mark it stale on redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cancel    <= 1'b0;
            beat_idx  <= '0;
            line_addr <= '0;
        end else if (grant) begin
            busy      <= 1'b1;
            cancel    <= 1'b0;
            beat_idx  <= '0;
            line_addr <= next_line;
        end else if (beat_in) begin
            beat_idx <= beat_idx + 1'b1;
            if (last_beat) begin
                busy   <= 1'b0;
                cancel <= 1'b0;
            end else if (redirect_valid) begin
                cancel <= 1'b1;
            end
        end else if (redirect_valid && busy) begin
            cancel <= 1'b1;
        end
    end

    // R11
    req_drop_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !bus_req);

    // R8
    stale_beat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && redirect_valid && !(bus_rvalid && last_beat)) |=> !beat_take);
endmodule

// File: rtl/code_prefetch_queue.sv
// Top of the prefetch queue controller: joins the fetch engine, the beat
// packer and the byte queue, and keeps the decoder-side byte address.
// Assumes a redirect is the only way to start or restart fetching.
module code_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned QUEUE_BYTES = 32,
    parameter int unsigned LINE_BYTES  = 16,
    parameter int unsigned BEAT_BYTES  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         redirect_valid,
    input  logic [ADDR_W-1:0]            redirect_addr,
    input  logic [ADDR_W-1:0]            seg_limit,
    input  logic                         page_present,
    input  logic                         data_pending,
    output logic                         bus_req,
    output logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_gnt,
    input  logic                         bus_rvalid,
    input  logic [BEAT_BYTES*BYTE_W-1:0] bus_rdata,
    output logic                         dec_valid,
    input  logic                         dec_ready,
    output logic [BYTE_W-1:0]            dec_byte,
    output logic [ADDR_W-1:0]            dec_addr
);
    localparam int unsigned CNT_W  = $clog2(QUEUE_BYTES + 1);
    localparam int unsigned PN_W   = $clog2(BEAT_BYTES + 1);
    localparam int unsigned BEAT_W = BEAT_BYTES * BYTE_W;

    logic [CNT_W-1:0]  q_count;
    logic [CNT_W-1:0]  q_free;
    logic              beat_take;
    logic [ADDR_W-1:0] beat_addr;
    logic [PN_W-1:0]   push_n;
    logic [BEAT_W-1:0] push_data;
    logic              pop;
    logic [ADDR_W-1:0] keep_from;
    logic [ADDR_W-1:0] head_addr;

    assign q_free    = CNT_W'(QUEUE_BYTES) - q_count;
    assign dec_valid = q_count != '0;
    assign pop       = dec_valid && dec_ready && !redirect_valid;
    assign dec_addr  = head_addr;

    pfq_fetch_ctrl #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .BEAT_BYTES (BEAT_BYTES),
        .CNT_W      (CNT_W)
    ) fetch_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .redirect_valid (redirect_valid),
        .redirect_addr  (redirect_addr),
        .data_pending   (data_pending),
        .page_present   (page_present),
        .seg_limit      (seg_limit),
        .free_bytes     (q_free),
        .bus_gnt        (bus_gnt),
        .bus_rvalid     (bus_rvalid),
        .bus_req        (bus_req),
        .bus_addr       (bus_addr),
        .beat_take      (beat_take),
        .beat_addr      (beat_addr)
    );

    pfq_beat_pack #(
        .ADDR_W     (ADDR_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) pack_i (
        .take      (beat_take),
        .beat_addr (beat_addr),
        .keep_from (keep_from),
        .beat_data (bus_rdata),
        .push_n    (push_n),
        .push_data (push_data)
    );

    pfq_byte_queue #(
        .DEPTH    (QUEUE_BYTES),
        .PUSH_MAX (BEAT_BYTES)
    ) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redirect_valid),
        .push_n    (push_n),
        .push_data (push_data),
        .pop       (pop),
        .head      (dec_byte),
        .count     (q_count)
    );

    // Hold the fetch target and step the head address on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_from <= '0;
            head_addr <= '0;
        end else if (redirect_valid) begin
            keep_from <= redirect_addr;
            head_addr <= redirect_addr;
        end else if (pop) begin
            head_addr <= head_addr + 1'b1;
        end
    end

    // R2
    req_yields_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !data_pending);

    // R7
    req_page_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> page_present);

    // R3
    redirect_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !dec_valid);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready && !redirect_valid) |=> (dec_addr == $past(dec_addr) + 1'b1));
endmodule

// File: tb/code_prefetch_queue_tb_top.sv
// Directed bench for the prefetch queue controller, with a bus responder
// that answers each granted line with four beats and a byte collector.
module code_prefetch_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [31:0] redirect_addr = '0;
    logic [31:0] seg_limit = 32'hFFFF_FFFF;
    logic        page_present = 1'b1;
    logic        data_pending = 1'b0;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_gnt = 1'b0;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        dec_valid;
    logic        dec_ready = 1'b1;
    logic [7:0]  dec_byte;
    logic [31:0] dec_addr;

    int checks = 0;
    int errors = 0;
    int grants = 0;
    logic [31:0] first_gnt = '0;
    logic [31:0] last_gnt = '0;
    bit overlap = 1'b0;
    bit done = 1'b0;
    logic [31:0] rec_a [512];
    logic [7:0]  rec_d [512];
    int rec_n = 0;

    always #10 clk = ~clk;

    code_prefetch_queue dut_i (
        .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .seg_limit(seg_limit),
        .page_present(page_present), .data_pending(data_pending),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_byte(dec_byte), .dec_addr(dec_addr)
    );

    function automatic logic [7:0] memb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Bus responder: grant each request, then return four beats in order.
    initial begin
        forever begin
            @(negedge clk); #1;
            bus_rvalid = 1'b0;
            if (rst_n && bus_req) begin
                logic [31:0] base;
                base = bus_addr;
                bus_gnt = 1'b1;
                grants++;
                if (grants == 1) first_gnt = base;
                last_gnt = base;
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk); #1;
                    bus_gnt = 1'b0;
                    bus_rvalid = 1'b1;
                    for (int b = 0; b < 4; b++)
                        bus_rdata[8*b +: 8] = memb(base + 32'(4*k + b));
                    if (bus_req) overlap = 1'b1;
                end
            end
        end
    end

    // Collector: log each byte that will transfer at the coming edge.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n && dec_valid && dec_ready && !redirect_valid && rec_n < 512) begin
                rec_a[rec_n] = dec_addr;
                rec_d[rec_n] = dec_byte;
                rec_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic redirect_to(input logic [31:0] a);
        @(negedge clk);
        redirect_valid = 1'b1;
        redirect_addr = a;
        rec_n = 0;
        grants = 0;
        @(negedge clk);
        redirect_valid = 1'b0;
    endtask

    // One check over a run of collected bytes: consecutive and correct data.
    task automatic check_stream(input logic [31:0] start, input int n, input string tag);
        int bad = -1;
        if (rec_n < n) begin
            check(1'b0, {tag, " byte count"}, 32'(rec_n), 32'(n));
            return;
        end
        for (int i = 0; i < n; i++)
            if (bad < 0 && (rec_a[i] != start + 32'(i) || rec_d[i] != memb(start + 32'(i))))
                bad = i;
        if (bad >= 0)
            check(1'b0, {tag, " stream"}, {rec_a[bad][23:0], rec_d[bad]},
                  {24'(start + 32'(bad)), memb(start + 32'(bad))});
        else
            check(1'b1, tag, 0, 0);
    endtask

    // R1: idle after reset until the first redirect.
    task automatic t_reset;
        bit any = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #3;
            if (dec_valid || bus_req) any = 1'b1;
        end
        check(!any, "R1 idle after reset", 32'(any), 0);
        check(grants == 0, "R1 no grant before redirect", 32'(grants), 0);
    endtask

    // R4 R5 R3: aligned restart delivers a consecutive stream.
    task automatic t_aligned;
        dec_ready = 1'b1;
        redirect_to(32'h100);
        wait_cycles(60);
        check(first_gnt == 32'h100, "R4 first line aligned", first_gnt, 32'h100);
        check_stream(32'h100, 40, "R5 R3 aligned stream");
    endtask

    // R4: unaligned restart fetches the base line, drops leading bytes.
    task automatic t_unaligned;
        redirect_to(32'h20B);
        wait_cycles(50);
        check(first_gnt == 32'h200, "R4 unaligned base line", first_gnt, 32'h200);
        check(rec_a[0] == 32'h20B, "R4 first byte at target", rec_a[0], 32'h20B);
        check_stream(32'h20B, 30, "R4 unaligned stream");
    endtask

    // R2: pending data transfers hold off all prefetch requests.
    task automatic t_data_pending;
        data_pending = 1'b1;
        redirect_to(32'h140);
        wait_cycles(20);
        check(grants == 0, "R2 no grant while data pending", 32'(grants), 0);
        check(!dec_valid, "R2 queue empty while blocked", 32'(dec_valid), 0);
        data_pending = 1'b0;
        wait_cycles(40);
        check(grants > 0, "R2 fetch resumes", 32'(grants), 1);
        check_stream(32'h140, 20, "R2 stream after release");
    endtask

    // R6: a limit partway through a line stops before that line.
    task automatic t_limit;
        seg_limit = 32'h327;
        redirect_to(32'h300);
        wait_cycles(80);
        #3;
        check(rec_n == 32, "R6 bytes inside limit", 32'(rec_n), 32);
        check(last_gnt == 32'h310, "R6 last line fetched", last_gnt, 32'h310);
        check(!bus_req, "R6 no request past limit", 32'(bus_req), 0);
        check_stream(32'h300, 32, "R6 stream");
        seg_limit = 32'hFFFF_FFFF;
    endtask

    // R7: a page not present stalls fetch without other effect.
    task automatic t_page;
        page_present = 1'b0;
        redirect_to(32'h700);
        wait_cycles(20);
        check(grants == 0, "R7 no grant to absent page", 32'(grants), 0);
        page_present = 1'b1;
        wait_cycles(40);
        check_stream(32'h700, 16, "R7 stream after page present");
    endtask

    // R8 R3 R11: redirect in the middle of a line fill.
    task automatic t_cancel;
        redirect_to(32'h400);
        while (grants < 1) @(negedge clk);
        redirect_to(32'h505);
        #3;
        check(!dec_valid, "R3 empty after redirect", 32'(dec_valid), 0);
        wait_cycles(40);
        check(first_gnt == 32'h500, "R8 first line after cancel", first_gnt, 32'h500);
        check_stream(32'h505, 20, "R8 stale beats dropped");
        check(!overlap, "R11 R8 no request during beats", 32'(overlap), 0);
    endtask

    // R9 R10: free-space rule and one byte per ready clock.
    task automatic t_backpressure;
        dec_ready = 1'b0;
        redirect_to(32'h800);
        wait_cycles(40);
        check(grants == 2, "R9 full queue holds two lines", 32'(grants), 2);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            dec_ready = 1'b1;
        end
        @(negedge clk);
        dec_ready = 1'b0;
        wait_cycles(20);
        check(rec_n == 15, "R10 one byte per ready clock", 32'(rec_n), 15);
        check(grants == 2, "R9 no request with 15 free", 32'(grants), 2);
        check_stream(32'h800, 15, "R10 drained bytes");
        dec_ready = 1'b1;
        @(negedge clk);
        dec_ready = 1'b0;
        wait_cycles(20);
        check(grants == 3, "R9 request once 16 free", 32'(grants), 3);
        check(last_gnt == 32'h820, "R9 third line address", last_gnt, 32'h820);
        dec_ready = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aligned();
        t_unaligned();
        t_data_pending();
        t_limit();
        t_page();
        t_cancel();
        t_backpressure();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule